// File: doc/BRIEF.md
# Byte-Lane Memory Bank Decoder

This block sits between a 20-bit processor address bus and a 16-bit memory made of two byte-wide banks. The even bank holds the low byte of every word and the odd bank holds the high byte. The block looks at the upper address bits to find which region is addressed. It then uses address bit 0 and an active-low high-byte enable to pick the byte lane or lanes. From these it drives per-chip selects for two ROM chips and two RAM chips, plus a shared read strobe and a shared write strobe.

Two regions sit at the top of the 1 MB space with no gap between them. ROM fills the top 8 KB, so the first instruction fetch after reset at FFFF0h lands in ROM. RAM fills the 8 KB directly below it. The block also holds behavioural storage: two RAM byte banks, and two ROM byte banks whose contents are computed from a seed parameter. Because of this, byte and word cycles can be run end to end. Read data is registered and appears one clock after the read cycle.

Top module: `lane_mem_decode`

## Requirements
- R1: A ROM select bit is only ever set for an address in FE000h–FFFFFh, and only during a read cycle.
- R2: A RAM select bit is only ever set for an address in FC000h–FDFFFh, during a read or a write cycle.
- R3: For an address outside FC000h–FFFFFh, no select is set, both strobes stay high, and the read data of that cycle is 0000h.
- R4: With addr[0] = 0, the even chip of the addressed region is selected (select bit 0). With addr[0] = 1, it is not.
- R5: With bhe_n = 0, the odd chip of the addressed region is selected (select bit 1). With bhe_n = 1, it is not. An even address with bhe_n = 0 sets both bits in the same cycle.
- R6: A cycle is a read when rd_n = 0 and wr_n = 1, and a write when wr_n = 0 and rd_n = 1. mem_rd_n is low during a read in either region. mem_wr_n is low only during a write to RAM.
- R7: One clock after a read, rdata carries the even-bank byte on bits 7:0 and the odd-bank byte on bits 15:8. A lane that is not selected reads as 00h. After any clock that is not a read, rdata is 0000h.
- R8: The ROM byte at region offset o (o = addr[12:0]) is SEED XOR f(o). Bit k of f(o) is the XOR of offset bits k and k+8, where those bits exist. The default SEED is 5Ah. This applies to the word at FFFF0h as well.
- R9: A write to the ROM region selects no chip, leaves mem_wr_n high, and leaves later ROM reads unchanged.
- R10: A RAM write stores wdata[7:0] into the even bank when lane 0 is selected, and wdata[15:8] into the odd bank when lane 1 is selected. An unselected byte keeps its old value.
- R11: When rd_n and wr_n are both low, no chip is selected, both strobes stay high, nothing is written, and the next rdata is 0000h.
- R12: While rst_n is low, rdata is cleared to 0000h on each clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 20 | Byte address |
| bhe_n | input | 1 | Active-low high-byte enable |
| rd_n | input | 1 | Active-low read request |
| wr_n | input | 1 | Active-low write request |
| wdata | input | 16 | Write data, high byte for the odd bank |
| rom_sel | output | 2 | ROM chip selects, bit 0 even, bit 1 odd |
| ram_sel | output | 2 | RAM chip selects, bit 0 even, bit 1 odd |
| mem_rd_n | output | 1 | Read strobe to the chips |
| mem_wr_n | output | 1 | Write strobe to the chips |
| rdata | output | 16 | Registered read data |

## Verification
The bench builds the block with its default parameters. These give a 20-bit address, a 13-bit region offset, ROM tag 7Fh, RAM tag 7Eh and seed 5Ah. With these values the reset fetch word at FFFF0h and both region boundaries (FBFFFh/FC000h, FDFFFh/FE000h) can be reached directly. Byte writes into either half of a previously written word show lane isolation. Cycles with both requests low, and writes aimed at ROM, show that nothing is disturbed. A batch of computed word writes and readbacks spread across the RAM region exercises many row indices.

// File: rtl/lane_pkg.sv
package lane_pkg;
    typedef enum logic [1:0] {
        RGN_NONE = 2'd0,
        RGN_ROM  = 2'd1,
        RGN_RAM  = 2'd2
    } rgn_e;

    typedef struct packed {
        logic [15:0] rdata;
    } lane_state_t;
endpackage

// File: rtl/lane_region_decode.sv
module lane_region_decode
    import lane_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int OFFS_W = 13,
    parameter logic [ADDR_W-OFFS_W-1:0] ROM_TAG = '1,
    parameter logic [ADDR_W-OFFS_W-1:0] RAM_TAG = '1 - 1'b1
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              bhe_n,
    input  logic              rd_n,
    input  logic              wr_n,
    output rgn_e              region,
    output logic [1:0]        lane,
    output logic              rd_go,
    output logic              wr_go
);
    localparam int TAG_W = ADDR_W - OFFS_W;

    logic [TAG_W-1:0] tag;

    always_comb begin
        tag = addr[ADDR_W-1:OFFS_W];
        if (tag == ROM_TAG) begin
            region = RGN_ROM;
        end else if (tag == RAM_TAG) begin
            region = RGN_RAM;
        end else begin
            region = RGN_NONE;
        end
        lane[0] = ~addr[0];
        lane[1] = ~bhe_n;
        rd_go   = ~rd_n & wr_n;
        wr_go   = ~wr_n & rd_n;
    end
endmodule

// File: rtl/lane_ram_bank.sv
module lane_ram_bank #(
    parameter int ROW_W = 12
) (
    input  logic             clk,
    input  logic             we,
    input  logic [ROW_W-1:0] row,
    input  logic [7:0]       wbyte,
    output logic [7:0]       rbyte
);
    localparam int DEPTH = 1 << ROW_W;

    logic [7:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem_q[row] <= wbyte;
        end
    end

    assign rbyte = mem_q[row];
endmodule

// File: rtl/lane_rom_bank.sv
module lane_rom_bank #(
    parameter int         ROW_W = 12,
    parameter bit         ODD   = 1'b0,
    parameter logic [7:0] SEED  = 8'h5A
) (
    input  logic [ROW_W-1:0] row,
    output logic [7:0]       rbyte
);
    localparam int OFFS_W = ROW_W + 1;

    logic [OFFS_W-1:0] offs;

    always_comb begin
        offs  = {row, ODD};
        rbyte = SEED;
        for (int i = 0; i < OFFS_W; i++) begin
            rbyte[i % 8] = rbyte[i % 8] ^ offs[i];
        end
    end
endmodule

// File: rtl/lane_mem_decode.sv
module lane_mem_decode
    import lane_pkg::*;
#(
    parameter int         ADDR_W   = 20,
    parameter int         OFFS_W   = 13,
    parameter logic [6:0] ROM_TAG  = 7'h7F,
    parameter logic [6:0] RAM_TAG  = 7'h7E,
    parameter logic [7:0] ROM_SEED = 8'h5A
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              bhe_n,
    input  logic              rd_n,
    input  logic              wr_n,
    input  logic [15:0]       wdata,
    output logic [1:0]        rom_sel,
    output logic [1:0]        ram_sel,
    output logic              mem_rd_n,
    output logic              mem_wr_n,
    output logic [15:0]       rdata
);
    localparam int ROW_W = OFFS_W - 1;
    localparam int LANES = 2;

    rgn_e             region;
    logic [1:0]       lane;
    logic             rd_go;
    logic             wr_go;
    logic [ROW_W-1:0] row;
    logic [7:0]       rom_byte [LANES];
    logic [7:0]       ram_byte [LANES];
    logic [LANES-1:0] ram_we;
    lane_state_t      st_d;
    lane_state_t      st_q;

    lane_region_decode #(
        .ADDR_W (ADDR_W),
        .OFFS_W (OFFS_W),
        .ROM_TAG(ROM_TAG),
        .RAM_TAG(RAM_TAG)
    ) u_dec (
        .addr  (addr),
        .bhe_n (bhe_n),
        .rd_n  (rd_n),
        .wr_n  (wr_n),
        .region(region),
        .lane  (lane),
        .rd_go (rd_go),
        .wr_go (wr_go)
    );

    assign row = addr[OFFS_W-1:1];

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign ram_we[g] = wr_go & (region == RGN_RAM) & lane[g];

        lane_ram_bank #(
            .ROW_W(ROW_W)
        ) u_ram (
            .clk  (clk),
            .we   (ram_we[g]),
            .row  (row),
            .wbyte(wdata[8*g +: 8]),
            .rbyte(ram_byte[g])
        );

        lane_rom_bank #(
            .ROW_W(ROW_W),
            .ODD  (g == 1),
            .SEED (ROM_SEED)
        ) u_rom (
            .row  (row),
            .rbyte(rom_byte[g])
        );

        assign rom_sel[g] = rd_go & (region == RGN_ROM) & lane[g];
        assign ram_sel[g] = (rd_go | wr_go) & (region == RGN_RAM) & lane[g];
    end

    assign mem_rd_n = ~(rd_go & (region != RGN_NONE));
    assign mem_wr_n = ~(wr_go & (region == RGN_RAM));

    always_comb begin
        st_d       = st_q;
        st_d.rdata = '0;
        if (rd_go && region != RGN_NONE) begin
            for (int g = 0; g < LANES; g++) begin
                if (lane[g]) begin
                    st_d.rdata[8*g +: 8] = (region == RGN_ROM) ? rom_byte[g] : ram_byte[g];
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rdata = st_q.rdata;
endmodule

// File: rtl/lane_mem_decode_chk.sv
module lane_mem_decode_chk #(
    parameter int         ADDR_W  = 20,
    parameter int         OFFS_W  = 13,
    parameter logic [6:0] ROM_TAG = 7'h7F,
    parameter logic [6:0] RAM_TAG = 7'h7E
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] addr,
    input logic              bhe_n,
    input logic              rd_n,
    input logic              wr_n,
    input logic [1:0]        rom_sel,
    input logic [1:0]        ram_sel,
    input logic              mem_wr_n,
    input logic [15:0]       rdata
);
    // R1
    rom_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rom_sel != 2'b00) |-> (addr[ADDR_W-1:OFFS_W] == ROM_TAG && !rd_n));

    // R2
    ram_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ram_sel != 2'b00) |-> (addr[ADDR_W-1:OFFS_W] == RAM_TAG));

    // R4
    even_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rom_sel[0] || ram_sel[0]) |-> !addr[0]);

    // R5
    odd_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rom_sel[1] || ram_sel[1]) |-> !bhe_n);

    // R9
    rom_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_n && addr[ADDR_W-1:OFFS_W] == ROM_TAG) |-> (mem_wr_n && rom_sel == 2'b00));

    // R11
    contention_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_n && !wr_n) |-> (rom_sel == 2'b00 && ram_sel == 2'b00 && mem_wr_n));

    // R7
    idle_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_n && rst_n) |=> (rdata == 16'h0000));

    // R12
    reset_data_chk: assert property (@(posedge clk)
        (rst_n === 1'b0) |=> (rdata == 16'h0000));
endmodule

bind lane_mem_decode lane_mem_decode_chk #(
    .ADDR_W (ADDR_W),
    .OFFS_W (OFFS_W),
    .ROM_TAG(ROM_TAG),
    .RAM_TAG(RAM_TAG)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .addr    (addr),
    .bhe_n   (bhe_n),
    .rd_n    (rd_n),
    .wr_n    (wr_n),
    .rom_sel (rom_sel),
    .ram_sel (ram_sel),
    .mem_wr_n(mem_wr_n),
    .rdata   (rdata)
);

// File: tb/sim_lane_mem_decode.sv
module sim_lane_mem_decode;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [19:0] addr = '0;
    logic        bhe_n = 1'b1;
    logic        rd_n = 1'b1;
    logic        wr_n = 1'b1;
    logic [15:0] wdata = '0;
    logic [1:0]  rom_sel;
    logic [1:0]  ram_sel;
    logic        mem_rd_n;
    logic        mem_wr_n;
    logic [15:0] rdata;

    int errors = 0;
    int checks = 0;
    logic [7:0] ram_m [int];

    always #4 clk = ~clk;

    lane_mem_decode u0 (
        .clk(clk), .rst_n(rst_n), .addr(addr), .bhe_n(bhe_n), .rd_n(rd_n),
        .wr_n(wr_n), .wdata(wdata), .rom_sel(rom_sel), .ram_sel(ram_sel),
        .mem_rd_n(mem_rd_n), .mem_wr_n(mem_wr_n), .rdata(rdata)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h (addr=%h)", req, act, exp, addr);
        end
    endtask

    function automatic logic [7:0] rom_ref(input int a);
        int o = a - 'hFE000;
        logic [7:0] lo = o[7:0];
        logic [7:0] hi = {3'b000, o[12:8]};
        return lo ^ hi ^ 8'h5A;
    endfunction

    // one bus cycle against a behavioural reference
    task automatic cyc(input int a, input bit bhe, input bit rd, input bit wr,
                       input logic [15:0] wd, input bit chk_data);
        bit in_rom, in_ram, is_rd, is_wr, lo, hi;
        logic [15:0] exp_rd;
        @(negedge clk);
        addr = a[19:0]; bhe_n = bhe; rd_n = rd; wr_n = wr; wdata = wd;
        #1;
        in_rom = (a >= 'hFE000) && (a <= 'hFFFFF);
        in_ram = (a >= 'hFC000) && (a <= 'hFDFFF);
        is_rd = !rd && wr;
        is_wr = !wr && rd;
        lo = (a % 2) == 0;
        hi = !bhe;
        check("R1/R4/R5 rom_sel", {30'd0, rom_sel},
              {30'd0, is_rd && in_rom && hi, is_rd && in_rom && lo});
        check("R2/R4/R5/R11 ram_sel", {30'd0, ram_sel},
              {30'd0, (is_rd || is_wr) && in_ram && hi, (is_rd || is_wr) && in_ram && lo});
        check("R3/R6 mem_rd_n", {31'd0, mem_rd_n}, {31'd0, !(is_rd && (in_rom || in_ram))});
        check("R6/R9 mem_wr_n", {31'd0, mem_wr_n}, {31'd0, !(is_wr && in_ram)});
        exp_rd = 16'h0000;
        if (is_rd && in_rom) begin
            if (lo) exp_rd[7:0]  = rom_ref(a - (a % 2));
            if (hi) exp_rd[15:8] = rom_ref(a | 1);
        end else if (is_rd && in_ram) begin
            if (lo) exp_rd[7:0]  = ram_m.exists(a - (a % 2)) ? ram_m[a - (a % 2)] : 8'h00;
            if (hi) exp_rd[15:8] = ram_m.exists(a | 1) ? ram_m[a | 1] : 8'h00;
        end
        @(posedge clk);
        if (is_wr && in_ram) begin
            if (lo) ram_m[a - (a % 2)] = wd[7:0];
            if (hi) ram_m[a | 1] = wd[15:8];
        end
        #1;
        if (chk_data) check("R7/R8/R10 rdata", {16'd0, rdata}, {16'd0, exp_rd});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check("R12 rdata in reset", {16'd0, rdata}, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
        cyc('h00000, 1, 1, 1, 16'h0, 1);                 // idle, R7
        // R8: reset fetch word, R4/R5 both lanes
        cyc('hFFFF0, 0, 0, 1, 16'h0, 1);
        cyc('hFFFF1, 0, 0, 1, 16'h0, 1);                 // odd byte only
        cyc('hFE000, 1, 0, 1, 16'h0, 1);                 // even byte only, boundary
        cyc('hFFFFE, 0, 0, 1, 16'h0, 1);
        // R10: word then byte writes
        cyc('hFC000, 0, 1, 0, 16'h1234, 1);
        cyc('hFC000, 0, 0, 1, 16'h0, 1);
        cyc('hFC002, 0, 1, 0, 16'h5566, 1);
        cyc('hFC003, 0, 1, 0, 16'hAB00, 1);
        cyc('hFC002, 0, 0, 1, 16'h0, 1);
        check("R10 odd byte merge", {16'd0, rdata}, 32'h0000AB66);
        cyc('hFDFFE, 0, 1, 0, 16'h7788, 1);
        cyc('hFDFFE, 1, 1, 0, 16'h00CD, 1);
        cyc('hFDFFE, 0, 0, 1, 16'h0, 1);
        check("R10 even byte merge", {16'd0, rdata}, 32'h000077CD);
        cyc('hFDFFF, 0, 0, 1, 16'h0, 1);                 // top of RAM, odd
        // R9: write to ROM ignored
        cyc('hFFFF0, 0, 1, 0, 16'hFFFF, 1);
        cyc('hFFFF0, 0, 0, 1, 16'h0, 1);
        // R3: outside both regions
        cyc('hFBFFE, 0, 0, 1, 16'h0, 1);
        cyc('hFBFFF, 0, 1, 0, 16'hEEEE, 1);
        cyc('h00010, 0, 0, 1, 16'h0, 1);
        // R11: both requests low, then check RAM untouched
        cyc('hFC000, 0, 0, 0, 16'h9999, 1);
        cyc('hFC000, 0, 0, 1, 16'h0, 1);
        check("R11 RAM kept", {16'd0, rdata}, 32'h00001234);
        // odd address with high byte disabled: no lane
        cyc('hFC001, 1, 0, 1, 16'h0, 1);
        // R2/R10: spread of word writes and readbacks
        for (int i = 0; i < 40; i++) begin
            int a = 'hFC000 + ((i * 397 + 6) % 4096) * 2;
            cyc(a, 0, 1, 0, 16'(i * 16'h0751 + 16'h0123), 1);
        end
        for (int i = 0; i < 40; i++) begin
            int a = 'hFC000 + ((i * 397 + 6) % 4096) * 2;
            cyc(a, 0, 0, 1, 16'h0, 1);
        end
        // R8: a sweep of ROM words
        for (int i = 0; i < 20; i++) begin
            cyc('hFE000 + i * 418, 0, 0, 1, 16'h0, 1);
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule